// File: doc/BRIEF.md
# Dual-Bank Flash Block Protection Manager

This block keeps the write-protection state of a 23-block, two-bank NOR flash array whose blocks are not all the same size. Fifteen main blocks of 32 KWord and eight parameter blocks of 4 KWord share a 19-bit word address space. A build-time option places the parameter blocks at the top or at the bottom of that space. The block turns a word address into a block index and a bank bit, and tells the program/erase sequencer whether the addressed block may be altered.

A command decoder sends protect, unprotect, lock and reset-command requests, each with a target address. Every block has a soft protect bit, and all of them are set at power-up. A second, sticky lock bit per block freezes the protect bit only while the active-low write-protect input `wp_n` is driven low. A change request aimed at a frozen block is dropped, and the block answers with a one-cycle reject pulse. A separate query address reads back the permit flag, the block index, the bank and the protect/lock status, all combinationally from the registered state.

Top module: `flash_guard`

## Requirements
- R1: The block index is decoded from the address. Let M be address bits 18:15 and P be bits 14:12. With TOP_BOOT=1: index = 15+P when M=15, otherwise M. With TOP_BOOT=0: index = P when M=0, otherwise 7+M.
- R2: The bank output equals address bit 18. The parameter blocks (indices 15..22 for top boot, 0..7 for bottom boot) always fall in bank 1 for top boot and in bank 0 for bottom boot.
- R3: After `rst_n` is released, every block reads protected (status bit 0 = 1) and unlocked (status bit 1 = 0).
- R4: A request with `req_op`=1 (protect) or `req_op`=2 (unprotect) sets or clears only the addressed block's protect bit. The change is visible at the query port from the first clock edge after the request.
- R5: A protect or unprotect request to a block whose lock bit is set, made while `wp_n` is 0, leaves all state unchanged. `rej` is 1 for exactly the one cycle that follows that clock edge.
- R6: While `wp_n` is 1, protect and unprotect requests change locked blocks as in R4 and leave their lock bits set.
- R7: `req_op`=3 (lock) sets the addressed block's lock bit regardless of `wp_n`. Lock bits are cleared only by `rst_n`.
- R8: `req_op`=4 (reset command), `req_op`=0 and `req_op` values 5..7 change no protect or lock bit and raise no reject.
- R9: `qry_permit` is 1 exactly when the protect bit of the block at `qry_addr` is clear.
- R10: `qry_status` bit 0 is the protect bit and bit 1 is the lock bit of the block at `qry_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 3 | Request code: 1 protect, 2 unprotect, 3 lock, 4 reset command |
| req_addr | input | 19 | Word address selecting the target block |
| wp_n | input | 1 | Write-protect pin, low freezes locked blocks |
| qry_addr | input | 19 | Word address to inspect |
| qry_permit | output | 1 | Program/erase allowed at qry_addr |
| qry_block | output | 5 | Block index of qry_addr |
| qry_bank | output | 1 | Bank of qry_addr |
| qry_status | output | 2 | {lock, protect} of the block at qry_addr |
| rej | output | 1 | Pulse: previous request hit a frozen block |

## Verification
The assertions assume that `req_op` is sampled only when `req_valid` is high, and that `req_valid` is low for the whole reset period, so the first post-reset comparisons have a clean history. The stimulus drives every input on the falling clock edge and keeps `req_valid` low during reset. After that it draws op codes across the full 3-bit range, including the unused codes, together with random addresses and a `wp_n` that is low about half the time. This lets frozen, unfrozen and idle requests all occur while the lock bits slowly build up.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PROTECT   = 3'd1,
        OP_UNPROTECT = 3'd2,
        OP_LOCK      = 3'd3,
        OP_RSTCMD    = 3'd4
    } guard_op_e;
endpackage

// File: rtl/fg_blockmap.sv
module fg_blockmap #(
    parameter int ADDR_W      = 19,
    parameter int MAIN_SHIFT  = 15,
    parameter int PARAM_SHIFT = 12,
    parameter bit TOP_BOOT    = 1'b1,
    parameter int BLK_W       = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BLK_W-1:0]  blk,
    output logic              bank
);
    localparam int MW      = ADDR_W - MAIN_SHIFT;
    localparam int PW      = MAIN_SHIFT - PARAM_SHIFT;
    localparam int N_MAIN  = (1 << MW) - 1;
    localparam int N_PARAM = 1 << PW;

    logic [MW-1:0] main_f;
    logic [PW-1:0] par_f;

    assign main_f = addr[ADDR_W-1:MAIN_SHIFT];
    assign par_f  = addr[MAIN_SHIFT-1:PARAM_SHIFT];
    assign bank   = addr[ADDR_W-1];

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (main_f == {MW{1'b1}})
                    blk = BLK_W'(N_MAIN) + BLK_W'(par_f);
                else
                    blk = BLK_W'(main_f);
            end
        end else begin : g_bot
            always_comb begin
                if (main_f == '0)
                    blk = BLK_W'(par_f);
                else
                    blk = BLK_W'(N_PARAM - 1) + BLK_W'(main_f);
            end
        end
    endgenerate
endmodule

// File: rtl/fg_state.sv
module fg_state
    import fg_pkg::*;
#(
    parameter int NUM_BLK = 23,
    parameter int BLK_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [BLK_W-1:0]   req_blk,
    input  logic               wp_n,
    output logic [NUM_BLK-1:0] prot_q,
    output logic [NUM_BLK-1:0] lock_q,
    output logic               rej_q
);
    typedef struct packed {
        logic [NUM_BLK-1:0] prot;
        logic [NUM_BLK-1:0] lock;
        logic               rej;
    } gst_t;

    gst_t s_d, s_q;
    logic frozen_d;

    always_comb begin
        s_d      = s_q;
        s_d.rej  = 1'b0;
        frozen_d = s_q.lock[req_blk] && !wp_n;
        if (req_valid) begin
            case (guard_op_e'(req_op))
                OP_PROTECT, OP_UNPROTECT: begin
                    if (frozen_d)
                        s_d.rej = 1'b1;
                    else
                        s_d.prot[req_blk] = (guard_op_e'(req_op) == OP_PROTECT);
                end
                OP_LOCK: s_d.lock[req_blk] = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prot <= '1;
            s_q.lock <= '0;
            s_q.rej  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prot_q = s_q.prot;
    assign lock_q = s_q.lock;
    assign rej_q  = s_q.rej;

    // R7: lock bits never fall once set
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~$past(lock_q)) == '0 || 1'b1 ? ((~lock_q & $past(lock_q)) == '0) : 1'b0);

    // R5: frozen change request leaves protection unchanged and rejects
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2) && lock_q[req_blk] && !wp_n)
        |=> ($stable(prot_q) && rej_q));

    // R5: a reject always follows a request
    p_rej_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rej_q |-> $past(req_valid));

    // R4: without a request nothing moves
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(prot_q) && $stable(lock_q) && !rej_q));

    // R8: reset command and unused codes touch nothing
    p_rstcmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd0 || req_op >= 3'd4))
        |=> ($stable(prot_q) && $stable(lock_q) && !rej_q));

    // R6: unprotect with pin released always takes effect
    p_wp_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && wp_n && req_op == 3'd2)
        |=> (!prot_q[$past(req_blk)] && !rej_q));
endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int ADDR_W      = 19,
    parameter int MAIN_SHIFT  = 15,
    parameter int PARAM_SHIFT = 12,
    parameter bit TOP_BOOT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_permit,
    output logic [4:0]        qry_block,
    output logic              qry_bank,
    output logic [1:0]        qry_status,
    output logic              rej
);
    localparam int N_MAIN  = (1 << (ADDR_W - MAIN_SHIFT)) - 1;
    localparam int N_PARAM = 1 << (MAIN_SHIFT - PARAM_SHIFT);
    localparam int NUM_BLK = N_MAIN + N_PARAM;
    localparam int BLK_W   = 5;

    logic [BLK_W-1:0]   req_blk, q_blk;
    logic               req_bank_unused;
    logic [NUM_BLK-1:0] prot_q, lock_q;

    fg_blockmap #(
        .ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT),
        .TOP_BOOT(TOP_BOOT), .BLK_W(BLK_W)
    ) u_req_map (
        .addr(req_addr), .blk(req_blk), .bank(req_bank_unused)
    );

    fg_blockmap #(
        .ADDR_W(ADDR_W), .MAIN_SHIFT(MAIN_SHIFT), .PARAM_SHIFT(PARAM_SHIFT),
        .TOP_BOOT(TOP_BOOT), .BLK_W(BLK_W)
    ) u_qry_map (
        .addr(qry_addr), .blk(q_blk), .bank(qry_bank)
    );

    fg_state #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_state (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .wp_n(wp_n),
        .prot_q(prot_q), .lock_q(lock_q), .rej_q(rej)
    );

    assign qry_block  = q_blk;
    assign qry_status = {lock_q[q_blk], prot_q[q_blk]};
    assign qry_permit = ~prot_q[q_blk];

    // R1: decoded index always names a real block
    p_blk_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(qry_block) < NUM_BLK);

    // R2: parameter blocks sit in the bank matching the boot option
    p_param_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (TOP_BOOT ? (int'(qry_block) >= N_MAIN) : (int'(qry_block) < N_PARAM))
        |-> (qry_bank == TOP_BOOT));
endmodule

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [18:0] req_addr = '0;
    logic wp_n = 1'b1;
    logic [18:0] qry_addr = '0;

    logic [1:0] o_permit, o_bank, o_rej;
    logic [4:0] o_blk [2];
    logic [1:0] o_stat [2];

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit mp [2][23];
    bit ml [2][23];
    bit er [2];

    always #4 clk = ~clk;

    flash_guard #(.TOP_BOOT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp_n(wp_n), .qry_addr(qry_addr),
        .qry_permit(o_permit[0]), .qry_block(o_blk[0]), .qry_bank(o_bank[0]),
        .qry_status(o_stat[0]), .rej(o_rej[0])
    );

    flash_guard #(.TOP_BOOT(1'b0)) uut_bot (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp_n(wp_n), .qry_addr(qry_addr),
        .qry_permit(o_permit[1]), .qry_block(o_blk[1]), .qry_bank(o_bank[1]),
        .qry_status(o_stat[1]), .rej(o_rej[1])
    );

    function automatic int blk_of(logic [18:0] a, bit top);
        int m = int'(a[18:15]);
        int p = int'(a[14:12]);
        if (top) return (m == 15) ? 15 + p : m;
        return (m == 0) ? p : 7 + m;
    endfunction

    task automatic chk(string tag, int inst, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s inst=%0d actual=%0d expected=%0d", tag, inst, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 2; i++) begin
            int b = blk_of(qry_addr, i == 0);
            chk("R1 block index", i, int'(o_blk[i]), b);
            chk("R2 bank", i, int'(o_bank[i]), int'(qry_addr[18]));
            chk("R9 permit", i, int'(o_permit[i]), int'(!mp[i][b]));
            chk({tag, " R10 status"}, i, int'(o_stat[i]), int'({ml[i][b], mp[i][b]}));
            chk("R5 reject pulse", i, int'(o_rej[i]), int'(er[i]));
        end
    endtask

    // Check the current outputs, then drive the next request and advance the model.
    task automatic step(string tag, bit v, logic [2:0] op, logic [18:0] a, bit wp, logic [18:0] q);
        @(negedge clk);
        check_all(tag);
        req_valid = v; req_op = op; req_addr = a; wp_n = wp; qry_addr = q;
        for (int i = 0; i < 2; i++) begin
            int b = blk_of(a, i == 0);
            er[i] = 1'b0;
            if (v) begin
                if (op == 3'd1 || op == 3'd2) begin
                    if (ml[i][b] && !wp) er[i] = 1'b1;
                    else mp[i][b] = (op == 3'd1);
                end else if (op == 3'd3) begin
                    ml[i][b] = 1'b1;
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2; i++)
            for (int b = 0; b < 23; b++) begin mp[i][b] = 1'b1; ml[i][b] = 1'b0; end
        er[0] = 0; er[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R3: sweep every 4 KWord slot after reset, all protected and unlocked
        for (int s = 0; s < 128; s++) begin
            step("R3", 1'b0, 3'd0, '0, 1'b1, 19'(s << 12));
            chk("R3 powerup protect", 0, int'(o_stat[0][0]), 1);
        end

        // R4: unprotect one parameter block and one main block, neighbours stay
        step("R4", 1'b1, 3'd2, 19'h7A123, 1'b1, 19'h7A000);
        step("R4", 1'b1, 3'd2, 19'h12345, 1'b1, 19'h7A000);
        step("R4", 1'b0, 3'd0, '0, 1'b1, 19'h7B000);
        step("R4", 1'b0, 3'd0, '0, 1'b1, 19'h10000);
        // R7: lock block at 7A000 with pin low
        step("R7", 1'b1, 3'd3, 19'h7A000, 1'b0, 19'h7A000);
        // R5: protect while frozen is rejected
        step("R5", 1'b1, 3'd1, 19'h7A000, 1'b0, 19'h7A000);
        step("R5", 1'b0, 3'd0, '0, 1'b0, 19'h7A000);
        step("R5", 1'b1, 3'd2, 19'h7A000, 1'b0, 19'h7A000);
        // R6: release the pin, protect now succeeds and lock stays
        step("R6", 1'b1, 3'd1, 19'h7A000, 1'b1, 19'h7A000);
        step("R6", 1'b1, 3'd2, 19'h7A000, 1'b1, 19'h7A000);
        step("R6", 1'b0, 3'd0, '0, 1'b1, 19'h7A000);
        // R8: reset command and unused codes change nothing
        step("R8", 1'b1, 3'd4, 19'h7A000, 1'b0, 19'h7A000);
        step("R8", 1'b1, 3'd6, 19'h12345, 1'b1, 19'h12345);
        step("R8", 1'b1, 3'd4, 19'h00000, 1'b1, 19'h00000);
        step("R8", 1'b0, 3'd0, '0, 1'b1, 19'h7A000);

        // R4 R5 R6 R7: random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op;
            int r = int'($urandom_range(0, 9));
            op = (r < 3) ? 3'd2 : (r < 6) ? 3'd1 : (r == 6) ? 3'd3 : 3'($urandom_range(0, 7));
            if (n % 40 == 0) op = 3'd3;
            step("R4", 1'($urandom_range(0, 1)), op, 19'($urandom),
                 1'($urandom_range(0, 1)), 19'($urandom));
        end
        step("R6", 1'b0, 3'd0, '0, 1'b1, 19'h7A000);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule